// File: doc/BRIEF.md
# 1-Wire Slot Timebase Divider

This block turns a system clock somewhere between 4 MHz and 128 MHz into a one-cycle enable pulse at about 1 MHz. The rest of a 1-Wire master uses that pulse to time its reset, presence and data slots. The host picks the division ratio by writing a 5-bit code. The code is not a plain binary count. Its low two bits choose an odd pre-divide of 1, 3, 5 or 7. Its upper three bits give an exponent n, which adds a further divide by 2^n. The tick period is therefore pre × 2^n system cycles.

The code is captured when the load strobe is high at a rising clock edge. The same edge clears both internal counters, so the output phase is fully determined by the moment of the write. Code zero is the off state, and reset leaves the block there. With code zero the block emits no tick at all, which stops every bus timing activity downstream. The host allows the derived tick about a millisecond to settle after a write. Once settled, the tick keeps running undisturbed until the next load.

Top module: `slot_tick_divider`

## Requirements
- R1: After synchronous reset the stored code is zero and `tick` stays low until a nonzero code is loaded.
- R2: With a stored nonzero code c, `tick` is periodic with a period of P = pre × 2^n clock cycles. Here pre is 1, 3, 5 or 7 for c[1:0] = 0, 1, 2, 3, and n is c[4:2].
- R3: Every tick is exactly one clock cycle wide, and it is low in the cycle that follows it.
- R4: When `load` is high at a rising edge, the first tick falls in the P-th cycle after that edge. The cycle right after the edge counts as the first.
- R5: While the stored code is zero, `tick` never asserts.
- R6: A load restarts the phase even when the new code equals the stored one. The first tick then comes P cycles after the reload, not at the old phase.
- R7: `div_in` is ignored while `load` is low. Changing it does not alter the tick period or phase.
- R8: The codes used for common clocks give a period in cycles equal to the input frequency in MHz:
  - 0x08 gives 4 cycles and 0x02 gives 5.
  - 0x05 gives 6, 0x03 gives 7 and 0x0C gives 8.
  - 0x06 gives 10, 0x09 gives 12 and 0x07 gives 14.
  - 0x10 gives 16, 0x0A gives 20 and 0x0D gives 24.
  - 0x0B gives 28, 0x14 gives 32 and 0x0E gives 40.
  - 0x11 gives 48, 0x0F gives 56 and 0x18 gives 64.
  - 0x12 gives 80, 0x15 gives 96, 0x13 gives 112 and 0x1C gives 128.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| load | input | 1 | Capture strobe for the divide code |
| div_in | input | 5 | Divide code: [1:0] odd pre-divide select, [4:2] power-of-two exponent |
| tick | output | 1 | One-cycle enable at the divided rate |

## Verification
A wrong pre-divide count or exponent mask shows up at the port as a wrong spacing between ticks. Such an error is visible at the second tick after a load, within two periods, and at most 1792 cycles for the slowest code. A counter that a load fails to clear moves the first tick away from cycle P, so it shows at the very first tick. A stuck or leaking stored code shows either as ticks while the code is zero or as a period change after `div_in` moves without `load`.

// File: rtl/slot_tick_pkg.sv
package slot_tick_pkg;
  localparam int unsigned SEL_W_DEF = 2;
  localparam int unsigned EXP_W_DEF = 3;

  // Last count value of the odd pre-divider for a selector value.
  function automatic int unsigned pre_last(input int unsigned sel);
    return 2 * sel;
  endfunction

  // Terminal count of the power-of-two stage for exponent n.
  function automatic int unsigned pow_last(input int unsigned n);
    return (32'd1 << n) - 32'd1;
  endfunction
endpackage

// File: rtl/slot_tick_oddcnt.sv
module slot_tick_oddcnt #(
  parameter int unsigned SEL_W = 2,
  localparam int unsigned CNT_W = SEL_W + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear,
  input  logic             enable,
  input  logic [SEL_W-1:0] sel,
  output logic [CNT_W-1:0] cnt,
  output logic             wrap
);
  logic [CNT_W-1:0] last;

  always_comb begin
    last = CNT_W'(slot_tick_pkg::pre_last(int'(sel)));
    wrap = enable && (cnt == last);
  end

  always_ff @(posedge clk) begin
    if (rst || clear || !enable) cnt <= '0;
    else if (wrap)               cnt <= '0;
    else                         cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/slot_tick_pow2cnt.sv
module slot_tick_pow2cnt #(
  parameter int unsigned EXP_W = 3,
  localparam int unsigned CNT_W = (1 << EXP_W) - 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear,
  input  logic             enable,
  input  logic             step,
  input  logic [EXP_W-1:0] expo,
  output logic             wrap
);
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] last;

  always_comb begin
    last = CNT_W'(slot_tick_pkg::pow_last(int'(expo)));
    wrap = enable && step && (cnt == last);
  end

  always_ff @(posedge clk) begin
    if (rst || clear || !enable) cnt <= '0;
    else if (step)               cnt <= wrap ? '0 : cnt + 1'b1;
  end
endmodule

// File: rtl/slot_tick_divider.sv
module slot_tick_divider #(
  parameter int unsigned SEL_W = slot_tick_pkg::SEL_W_DEF,
  parameter int unsigned EXP_W = slot_tick_pkg::EXP_W_DEF,
  localparam int unsigned CODE_W = SEL_W + EXP_W,
  localparam int unsigned PRE_W  = SEL_W + 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [CODE_W-1:0] div_in,
  output logic              tick
);
  logic [CODE_W-1:0] div_q;
  logic              active;
  logic [PRE_W-1:0]  pre_cnt;
  logic              pre_wrap;
  logic              pow_wrap;

  always_ff @(posedge clk) begin
    if (rst)       div_q <= '0;
    else if (load) div_q <= div_in;
  end

  assign active = (div_q != '0);

  slot_tick_oddcnt #(.SEL_W(SEL_W)) u_pre (
    .clk    (clk),
    .rst    (rst),
    .clear  (load),
    .enable (active),
    .sel    (div_q[SEL_W-1:0]),
    .cnt    (pre_cnt),
    .wrap   (pre_wrap)
  );

  slot_tick_pow2cnt #(.EXP_W(EXP_W)) u_pow (
    .clk    (clk),
    .rst    (rst),
    .clear  (load),
    .enable (active),
    .step   (pre_wrap),
    .expo   (div_q[CODE_W-1:SEL_W]),
    .wrap   (pow_wrap)
  );

  assign tick = pow_wrap;
endmodule

// File: rtl/slot_tick_divider_chk.sv
module slot_tick_divider_chk #(
  parameter int unsigned SEL_W = 2,
  parameter int unsigned EXP_W = 3,
  localparam int unsigned CODE_W = SEL_W + EXP_W,
  localparam int unsigned PRE_W  = SEL_W + 1
) (
  input logic              clk,
  input logic              rst,
  input logic              load,
  input logic              tick,
  input logic [CODE_W-1:0] div_q,
  input logic [PRE_W-1:0]  pre_cnt
);
  assert_single_pulse_R3: assert property (@(posedge clk) disable iff (rst)
    tick |=> !tick);

  assert_zero_quiet_R5: assert property (@(posedge clk) disable iff (rst)
    (div_q == '0) |-> !tick);

  assert_load_no_early_R4: assert property (@(posedge clk) disable iff (rst)
    load |=> !tick);

  assert_code_held_R7: assert property (@(posedge clk) disable iff (rst)
    !load |=> $stable(div_q));

  assert_pre_range_R2: assert property (@(posedge clk) disable iff (rst)
    (div_q != '0) |-> (pre_cnt <= {div_q[SEL_W-1:0], 1'b0}));
endmodule

bind slot_tick_divider slot_tick_divider_chk #(.SEL_W(SEL_W), .EXP_W(EXP_W)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .load    (load),
  .tick    (tick),
  .div_q   (div_q),
  .pre_cnt (pre_cnt)
);

// File: tb/sim_slot_tick_divider.sv
`timescale 1ns/1ps
module sim_slot_tick_divider;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       load = 1'b0;
  logic [4:0] div_in = '0;
  logic       tick;

  int vectors = 0;
  int errors  = 0;
  int cycles  = 0;

  slot_tick_divider u0 (.clk(clk), .rst(rst), .load(load), .div_in(div_in), .tick(tick));

  always #5 clk = ~clk;

  always @(posedge clk) begin
    cycles++;
    if (cycles > 190000) begin
      errors++;
      $display("FAIL watchdog: actual %0d cycles, expected fewer", cycles);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  function automatic int exp_period(input logic [4:0] c);
    int p;
    case (c[1:0])
      2'd0: p = 1;
      2'd1: p = 3;
      2'd2: p = 5;
      default: p = 7;
    endcase
    for (int i = 0; i < int'(c[4:2]); i++) p = p + p;
    return p;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Drive a load; returns at the negedge after the capture edge (cycle 1).
  task automatic do_load(input logic [4:0] c);
    @(negedge clk);
    load = 1'b1; div_in = c;
    @(negedge clk);
    load = 1'b0;
  endtask

  // Sample from cycle 1 onward; report first and second tick and count.
  task automatic observe(input int span, output int first, output int second, output int n);
    first = 0; second = 0; n = 0;
    for (int k = 1; k <= span; k++) begin
      if (k > 1) @(negedge clk);
      if (tick) begin
        n++;
        if (n == 1) first = k;
        else if (n == 2) second = k;
      end
    end
  endtask

  task automatic run_code(input string req, input logic [4:0] c, input int p);
    int f, s, n;
    do_load(c);
    observe(2 * p + 1, f, s, n);
    check({req, " R4 first tick"}, f, p);
    check({req, " R2 second tick"}, s, 2 * p);
    check({req, " R3 tick count"}, n, 2);
  endtask

  task automatic t_reset();
    int n = 0;
    for (int k = 0; k < 30; k++) begin
      @(negedge clk);
      if (tick) n++;
    end
    check("R1 ticks after reset", n, 0);
  endtask

  task automatic t_table();
    logic [4:0] codes [21] = '{5'h08, 5'h02, 5'h05, 5'h03, 5'h0C, 5'h06, 5'h09,
                               5'h07, 5'h10, 5'h0A, 5'h0D, 5'h0B, 5'h14, 5'h0E,
                               5'h11, 5'h0F, 5'h18, 5'h12, 5'h15, 5'h13, 5'h1C};
    int mhz [21] = '{4, 5, 6, 7, 8, 10, 12, 14, 16, 20, 24, 28, 32, 40,
                     48, 56, 64, 80, 96, 112, 128};
    for (int i = 0; i < 21; i++) run_code("R8", codes[i], mhz[i]);
  endtask

  task automatic t_all_codes();
    for (int c = 1; c < 32; c++) run_code("R2", 5'(c), exp_period(5'(c)));
  endtask

  task automatic t_zero();
    int f, s, n;
    do_load(5'h08);
    do_load(5'h00);
    observe(2000, f, s, n);
    check("R5 ticks with code zero", n, 0);
  endtask

  task automatic t_ignore();
    int f, s, n;
    do_load(5'h08);
    @(negedge clk); div_in = 5'h1C;   // cycle 2, no load
    @(negedge clk); div_in = 5'h03;   // cycle 3
    observe(6, f, s, n);              // cycles 3..8 relative
    check("R7 first tick after div_in change", f, 2);  // absolute cycle 4
    check("R7 second tick after div_in change", s, 6); // absolute cycle 8
  endtask

  task automatic t_restart();
    int f, s, n;
    do_load(5'h1C);
    for (int k = 0; k < 49; k++) @(negedge clk);
    run_code("R6 reload same code", 5'h1C, 128);
    do_load(5'h0C);
    for (int k = 0; k < 5; k++) @(negedge clk);
    do_load(5'h0C);
    observe(17, f, s, n);
    check("R6 first tick after mid-period reload", f, 8);
    check("R6 tick count after reload", n, 2);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 tick during reset", int'(tick), 0);
    rst = 1'b0;
    t_reset();
    t_table();
    t_all_codes();
    t_zero();
    t_ignore();
    t_restart();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule